// File: doc/BRIEF.md
# OSD Sync Polarity and Interrupt Controller

This block holds the 8-bit control byte of an on-screen-display engine and the sync conditioning logic that the byte steers. A CPU reaches the byte through a small special-function-register port that has address, read strobe, write strobe and a read-modify-write qualifier. The raw vertical and horizontal sync inputs are synchronised and brought to a common active-high sense. The leading edge of active VSYNC raises an interrupt flag. A one-clock field-reference pulse, taken on either the leading or the trailing edge, clears a downstream vertical state counter.

The same byte sets the pin polarity of the 3-bit video code, the video-control strobe and the background/foreground output. The video code and the strobe are blanked for as long as VSYNC is active. The interrupt flag is guarded against bit-level read-modify-write instructions that aim at other bits of the byte. Such an instruction writes back the flag value it read, and that stale value must not undo a hardware set that landed between its read and its write. Character generation, the vertical start counter and the CPU are outside the block.

Top module: `osd_sync_ctl`

## Requirements
- R1: The control byte answers only at address C0h and resets to 00h. A plain write loads all eight bits. A read with a matching address returns the byte on `sfr_rdata`; otherwise `sfr_rdata` is 00h. Bit map: 7 interrupt flag, 6 field-reference edge select, 5 HSYNC invert, 4 VSYNC invert, 3 video-control invert, 2 video-code invert, 1 double-height, 0 background/foreground enable. Bit 1 drives `dbl_height`.
- R2: Each raw sync input passes through two flip-flops. A change of `vsync_raw` ahead of clock edge k shows on `vsync_act` after edge k+1. A leading (inactive-to-active) edge of the active VSYNC sets the interrupt flag at edge k+2.
- R3: With bit 4 = 0, VSYNC is active when `vsync_raw` is high. With bit 4 = 1, it is active when `vsync_raw` is low. The flag therefore follows a rising or a falling raw edge.
- R4: `field_ref` is a one-clock pulse. It is high between edges k+1 and k+2 for the leading edge when bit 6 = 0, and for the trailing edge when bit 6 = 1. The other edge gives no pulse.
- R5: `hsync_act` equals `hsync_raw` XOR bit 5, after the same two-edge latency.
- R6: When `vsync_act` is high at a clock edge, the video code registered at that edge is black (internal 000) and the video-control strobe is inactive, whatever the pixel inputs are.
- R7: `vid_out` is registered and equals the internal code (the pixel code, or 000 when blanked) XOR bit 2 replicated on every bit.
- R8: `vctl_out` is registered and equals (`pix_show` AND NOT blank) XOR bit 3.
- R9: `bgfg_out` is registered. With bit 0 = 1 it is low for a foreground pixel (`pix_fg` = 1) and high otherwise. With bit 0 = 0 it stays high.
- R10: A write that carries `sfr_rmw` = 1 changes the flag only when its bit 7 differs from the flag value returned by the latest read of the byte. Otherwise the flag keeps its value, and a hardware set in the same cycle still takes effect.
- R11: A write that changes the flag beats a hardware set in the same cycle, and a hardware set beats `irq_ack`.
- R12: `irq_ack` clears the flag at the next edge when no set and no flag write occur in that cycle. `irq` always shows the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Write belongs to a read-modify-write instruction |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, 00h when not selected |
| irq_ack | input | 1 | Interrupt vectored, clears the flag |
| irq | output | 1 | Interrupt flag |
| vsync_raw | input | 1 | Raw vertical sync |
| hsync_raw | input | 1 | Raw horizontal sync |
| vsync_act | output | 1 | Synchronised active-high VSYNC |
| hsync_act | output | 1 | Synchronised active-high HSYNC |
| field_ref | output | 1 | One-clock field reference pulse |
| dbl_height | output | 1 | Double-height setting for the character generator |
| pix_code | input | 3 | Internal video code of the current pixel |
| pix_show | input | 1 | Current pixel is to be shown |
| pix_fg | input | 1 | Current pixel is a foreground bit |
| vid_out | output | 3 | Video code pins |
| vctl_out | output | 1 | Video-control pin |
| bgfg_out | output | 1 | Background/foreground pin |

## Verification
The output stage is swept over every combination of the three output polarity bits, the blanking state, all eight pixel codes and the show and foreground inputs. This separates a wrong inversion, a missing blank and a leaking foreground signal. The VSYNC path is driven with both input polarities and both edge selects, so a flag or pulse on the wrong edge shows up as a mismatch in a precise cycle. The flag is also tried with deliberately colliding events: an acknowledge on the set cycle, a plain clearing write on the set cycle, and a read-modify-write of another bit whose read came before the set. These tell the three priority paths and the stale-write guard apart.

// File: rtl/osd_ctl_pkg.sv
package osd_ctl_pkg;

  // Control byte, MSB first; bit positions are software visible.
  typedef struct packed {
    logic irq;        // 7 interrupt flag
    logic ref_trail;  // 6 field reference on trailing edge
    logic hs_inv;     // 5 HSYNC active low
    logic vs_inv;     // 4 VSYNC active low
    logic ctl_inv;    // 3 video-control pin active low
    logic vid_inv;    // 2 video code pins inverted
    logic dbl;        // 1 double height
    logic bgfg_en;    // 0 background/foreground output enable
  } osd_cfg_t;

  localparam int CFG_W   = $bits(osd_cfg_t);
  localparam int IRQ_BIT = CFG_W - 1;

endpackage

// File: rtl/osd_ctl_regs.sv
module osd_ctl_regs
  import osd_ctl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic              sfr_rmw,
  input  logic [CFG_W-1:0]  sfr_wdata,
  input  logic              irq_set,
  input  logic              irq_ack,
  output osd_cfg_t          cfg,
  output logic [CFG_W-1:0]  sfr_rdata
);

  logic     hit_wr, hit_rd;
  logic     irq_wr;
  logic     cfg_en;
  osd_cfg_t cfg_q, cfg_d;
  logic     snap_q, snap_d;

  assign hit_wr = sfr_wr && (sfr_addr == REG_ADDR);
  assign hit_rd = sfr_rd && (sfr_addr == REG_ADDR);

  // A read-modify-write only owns the flag when it changes the value it read.
  assign irq_wr = hit_wr && (!sfr_rmw || (sfr_wdata[IRQ_BIT] != snap_q));
  assign cfg_en = hit_wr || irq_set || irq_ack;

  always_comb begin
    cfg_d  = cfg_q;
    snap_d = snap_q;
    if (hit_rd) snap_d = cfg_q.irq;
    if (hit_wr) cfg_d = osd_cfg_t'(sfr_wdata);
    if (irq_wr)       cfg_d.irq = sfr_wdata[IRQ_BIT];
    else if (irq_set) cfg_d.irq = 1'b1;
    else if (irq_ack) cfg_d.irq = 1'b0;
    else              cfg_d.irq = cfg_q.irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= 1'b0;
    end else if (hit_rd) begin
      snap_q <= snap_d;
    end
  end

  assign cfg       = cfg_q;
  assign sfr_rdata = hit_rd ? cfg_q : '0;

endmodule

// File: rtl/osd_sync_cond.sv
module osd_sync_cond #(
  parameter int STAGES = 2,
  parameter int CH     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] raw,
  input  logic [CH-1:0] inv,
  output logic [CH-1:0] act,
  output logic          lead,
  output logic          trail
);

  localparam int LAST = STAGES - 1;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], raw[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign act[c] = sh_q[LAST] ^ inv[c];
  end

  // Edge detection on channel 0 (vertical sync).
  logic prev_q, prev_d;

  always_comb begin
    prev_d = act[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign lead  =  act[0] && !prev_q;
  assign trail = !act[0] &&  prev_q;

endmodule

// File: rtl/osd_video_out.sv
module osd_video_out #(
  parameter int VID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank,
  input  logic [VID_W-1:0] pix_code,
  input  logic             pix_show,
  input  logic             pix_fg,
  input  logic             vid_inv,
  input  logic             ctl_inv,
  input  logic             bgfg_en,
  output logic [VID_W-1:0] vid_out,
  output logic             vctl_out,
  output logic             bgfg_out
);

  localparam logic [VID_W-1:0] BLACK = '0;

  logic [VID_W-1:0] vid_d, vid_q;
  logic             vctl_d, vctl_q;
  logic             bgfg_d, bgfg_q;
  logic [VID_W-1:0] code_int;

  always_comb begin
    code_int = blank ? BLACK : pix_code;
    vid_d    = code_int ^ {VID_W{vid_inv}};
    vctl_d   = (pix_show && !blank) ^ ctl_inv;
    bgfg_d   = bgfg_en ? !pix_fg : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q  <= BLACK;
      vctl_q <= 1'b0;
      bgfg_q <= 1'b1;
    end else begin
      vid_q  <= vid_d;
      vctl_q <= vctl_d;
      bgfg_q <= bgfg_d;
    end
  end

  assign vid_out  = vid_q;
  assign vctl_out = vctl_q;
  assign bgfg_out = bgfg_q;

endmodule

// File: rtl/osd_sync_ctl.sv
module osd_sync_ctl
  import osd_ctl_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'hC0,
  parameter int                VID_W       = 3,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic              sfr_rmw,
  input  logic [CFG_W-1:0]  sfr_wdata,
  output logic [CFG_W-1:0]  sfr_rdata,
  input  logic              irq_ack,
  output logic              irq,
  input  logic              vsync_raw,
  input  logic              hsync_raw,
  output logic              vsync_act,
  output logic              hsync_act,
  output logic              field_ref,
  output logic              dbl_height,
  input  logic [VID_W-1:0]  pix_code,
  input  logic              pix_show,
  input  logic              pix_fg,
  output logic [VID_W-1:0]  vid_out,
  output logic              vctl_out,
  output logic              bgfg_out
);

  localparam int N_SYNC = 2;

  osd_cfg_t          cfg_q;
  logic [N_SYNC-1:0] sync_raw, sync_inv, sync_act;
  logic              vs_lead, vs_trail;

  assign sync_raw = {hsync_raw, vsync_raw};
  assign sync_inv = {cfg_q.hs_inv, cfg_q.vs_inv};

  osd_ctl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_rd    (sfr_rd),
    .sfr_rmw   (sfr_rmw),
    .sfr_wdata (sfr_wdata),
    .irq_set   (vs_lead),
    .irq_ack   (irq_ack),
    .cfg       (cfg_q),
    .sfr_rdata (sfr_rdata)
  );

  osd_sync_cond #(.STAGES(SYNC_STAGES), .CH(N_SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (sync_raw),
    .inv   (sync_inv),
    .act   (sync_act),
    .lead  (vs_lead),
    .trail (vs_trail)
  );

  osd_video_out #(.VID_W(VID_W)) u_vid (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank    (sync_act[0]),
    .pix_code (pix_code),
    .pix_show (pix_show),
    .pix_fg   (pix_fg),
    .vid_inv  (cfg_q.vid_inv),
    .ctl_inv  (cfg_q.ctl_inv),
    .bgfg_en  (cfg_q.bgfg_en),
    .vid_out  (vid_out),
    .vctl_out (vctl_out),
    .bgfg_out (bgfg_out)
  );

  assign vsync_act  = sync_act[0];
  assign hsync_act  = sync_act[1];
  assign field_ref  = cfg_q.ref_trail ? vs_trail : vs_lead;
  assign irq        = cfg_q.irq;
  assign dbl_height = cfg_q.dbl;

endmodule

// File: rtl/osd_sync_ctl_chk.sv
module osd_sync_ctl_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0,
  parameter int                VID_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic              sfr_rmw,
  input logic [7:0]        sfr_wdata,
  input logic              irq_ack,
  input logic              irq,
  input logic [7:0]        cfg,
  input logic              vs_lead,
  input logic              vs_trail,
  input logic              field_ref,
  input logic              vsync_act,
  input logic [VID_W-1:0]  vid_out,
  input logic              vctl_out,
  input logic              bgfg_out
);

  logic wr_hit;
  assign wr_hit = sfr_wr && (sfr_addr == REG_ADDR);

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !sfr_rmw |=> cfg[6:0] == $past(sfr_wdata[6:0])); // R1

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !sfr_rmw |=> irq == $past(sfr_wdata[7])); // R11

  AST_LEAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead && !wr_hit |=> irq); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !vs_lead && !wr_hit |=> !irq); // R12

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vs_lead, vs_trail})); // R4

  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    field_ref && !wr_hit |=> !field_ref); // R4

  AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_act && !wr_hit |=> (vid_out == {VID_W{cfg[2]}}) && (vctl_out == cfg[3])); // R6

  AST_BG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] && !wr_hit |=> bgfg_out); // R9

endmodule

bind osd_sync_ctl osd_sync_ctl_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .VID_W(VID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_rmw   (sfr_rmw),
  .sfr_wdata (sfr_wdata),
  .irq_ack   (irq_ack),
  .irq       (irq),
  .cfg       (cfg_q),
  .vs_lead   (vs_lead),
  .vs_trail  (vs_trail),
  .field_ref (field_ref),
  .vsync_act (vsync_act),
  .vid_out   (vid_out),
  .vctl_out  (vctl_out),
  .bgfg_out  (bgfg_out)
);

// File: tb/sim_osd_sync_ctl.sv
module sim_osd_sync_ctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic       sfr_wr, sfr_rd, sfr_rmw;
  logic [7:0] sfr_wdata, sfr_rdata;
  logic       irq_ack, irq;
  logic       vsync_raw, hsync_raw, vsync_act, hsync_act, field_ref, dbl_height;
  logic [2:0] pix_code, vid_out;
  logic       pix_show, pix_fg, vctl_out, bgfg_out;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_sync_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_rmw(sfr_rmw), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_ack(irq_ack),
    .irq(irq), .vsync_raw(vsync_raw), .hsync_raw(hsync_raw), .vsync_act(vsync_act),
    .hsync_act(hsync_act), .field_ref(field_ref), .dbl_height(dbl_height),
    .pix_code(pix_code), .pix_show(pix_show), .pix_fg(pix_fg), .vid_out(vid_out),
    .vctl_out(vctl_out), .bgfg_out(bgfg_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] d, input logic rmw);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1; sfr_rmw = rmw;
    step(1);
    sfr_wr = 1'b0; sfr_rmw = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    sfr_addr = ADDR; sfr_rd = 1'b1;
    #1 d = sfr_rdata;
    step(1);
    sfr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; sfr_addr = '0; sfr_wr = 0; sfr_rd = 0; sfr_rmw = 0; sfr_wdata = '0;
    irq_ack = 0; vsync_raw = 0; hsync_raw = 0; pix_code = '0; pix_show = 0; pix_fg = 0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state and address decode
    rd(v);                         check("R1 reset value", v, 8'h00);
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
    check("R7 vid reset", {5'd0, vid_out}, 8'h00);
    check("R8 vctl reset", {7'd0, vctl_out}, 8'h00);
    check("R9 bgfg reset", {7'd0, bgfg_out}, 8'h01);
    wr_at(8'hC1, 8'hFF, 1'b0);
    rd(v);                         check("R1 other address ignored", v, 8'h00);
    sfr_addr = 8'hC1; sfr_rd = 1'b1;
    #1 check("R1 rdata unselected", sfr_rdata, 8'h00);
    step(1); sfr_rd = 1'b0;
    wr_at(ADDR, 8'h6F, 1'b0);
    rd(v);                         check("R1 write/readback", v, 8'h6F);
    check("R1 dbl_height", {7'd0, dbl_height}, 8'h01);
    wr_at(ADDR, 8'h00, 1'b0);

    // R2 R3 R4 leading edge, both polarities, edge select 0
    for (int pv = 0; pv < 2; pv++) begin
      wr_at(ADDR, 8'(pv << 4), 1'b0);
      vsync_raw = pv[0];
      step(4);
      wr_at(ADDR, 8'(pv << 4), 1'b0);
      check("R3 flag clear before edge", {7'd0, irq}, 8'h00);
      vsync_raw = ~pv[0];
      step(2);
      check("R3 vsync_act", {7'd0, vsync_act}, 8'h01);
      check("R4 lead pulse lv=0", {7'd0, field_ref}, 8'h01);
      step(1);
      check("R2 flag set on leading edge", {7'd0, irq}, 8'h01);
      check("R4 pulse one clock", {7'd0, field_ref}, 8'h00);
      vsync_raw = pv[0];
      step(2);
      check("R4 no trail pulse lv=0", {7'd0, field_ref}, 8'h00);
      check("R3 vsync inactive", {7'd0, vsync_act}, 8'h00);
      step(2);
    end

    // R4 trailing edge select
    wr_at(ADDR, 8'h40, 1'b0);
    vsync_raw = 1'b0; step(4);
    wr_at(ADDR, 8'h40, 1'b0);
    vsync_raw = 1'b1; step(2);
    check("R4 no lead pulse lv=1", {7'd0, field_ref}, 8'h00);
    step(1);
    check("R2 flag with lv=1", {7'd0, irq}, 8'h01);
    vsync_raw = 1'b0; step(2);
    check("R4 trail pulse lv=1", {7'd0, field_ref}, 8'h01);
    step(1);
    check("R4 trail pulse ends", {7'd0, field_ref}, 8'h00);

    // R5 HSYNC polarity
    for (int ph = 0; ph < 2; ph++) begin
      wr_at(ADDR, 8'(ph << 5), 1'b0);
      for (int h = 0; h < 2; h++) begin
        hsync_raw = h[0];
        step(2);
        check("R5 hsync_act", {7'd0, hsync_act}, {7'd0, h[0] ^ ph[0]});
      end
    end

    // R12 acknowledge clears
    wr_at(ADDR, 8'h80, 1'b0);
    check("R1 software set of flag", {7'd0, irq}, 8'h01);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    check("R12 ack clears flag", {7'd0, irq}, 8'h00);

    // R11 set beats ack
    vsync_raw = 1'b0; step(3);
    wr_at(ADDR, 8'h00, 1'b0);
    vsync_raw = 1'b1; step(2);
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    check("R11 set beats ack", {7'd0, irq}, 8'h01);

    // R11 flag write beats set
    vsync_raw = 1'b0; step(3);
    wr_at(ADDR, 8'h00, 1'b0);
    vsync_raw = 1'b1; step(2);
    wr_at(ADDR, 8'h00, 1'b0);
    check("R11 write beats set", {7'd0, irq}, 8'h00);
    step(1);
    check("R11 flag stays clear", {7'd0, irq}, 8'h00);

    // R10 read-modify-write of another bit straddling a hardware set
    vsync_raw = 1'b0; step(3);
    wr_at(ADDR, 8'h00, 1'b0);
    vsync_raw = 1'b1;
    rd(v);
    check("R10 read before set", v, 8'h00);
    step(1);
    wr_at(ADDR, v | 8'h01, 1'b1);
    check("R10 set survives stale rmw", {7'd0, irq}, 8'h01);
    rd(v);
    check("R10 other bit written", v, 8'h81);
    wr_at(ADDR, v & 8'h7F, 1'b1);
    check("R10 rmw aimed at flag clears", {7'd0, irq}, 8'h00);
    rd(v);
    wr_at(ADDR, v | 8'h04, 1'b1);
    check("R10 rmw keeps clear flag", {7'd0, irq}, 8'h00);
    vsync_raw = 1'b0; step(3);

    // R6 R7 R8 R9 output stage sweep
    for (int c = 0; c < 8; c++) begin
      logic po, pc, bfe;
      po = c[0]; pc = c[1]; bfe = c[2];
      wr_at(ADDR, {4'b0000, pc, po, 1'b0, bfe}, 1'b0);
      for (int bl = 0; bl < 2; bl++) begin
        vsync_raw = bl[0];
        step(3);
        for (int k = 0; k < 32; k++) begin
          logic [2:0] code, exp_v;
          logic s, f, exp_c, exp_b;
          code = k[2:0]; s = k[3]; f = k[4];
          pix_code = code; pix_show = s; pix_fg = f;
          step(1);
          exp_v = (bl[0] ? 3'b000 : code) ^ {3{po}};
          exp_c = (s & ~bl[0]) ^ pc;
          exp_b = bfe ? ~f : 1'b1;
          check(bl[0] ? "R6 blanked video" : "R7 video code", {5'd0, vid_out}, {5'd0, exp_v});
          check(bl[0] ? "R6 blanked strobe" : "R8 video strobe", {7'd0, vctl_out}, {7'd0, exp_c});
          check("R9 bg/fg output", {7'd0, bgfg_out}, {7'd0, exp_b});
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule